// File: doc/BRIEF.md
# Teaching-ISA Processor Core

This block is a small multi-cycle processor for a compact load/store instruction set of the kind used to teach machine programming. It runs from one synchronous memory that holds both program and data. Each instruction is one memory word. The core fetches it, decodes and executes it, and for loads adds a third cycle to take the data word. The core keeps a register file, a program counter and two condition flags that only a compare instruction writes. The word width, the memory address width and the register count are parameters.

The sequencer has four named states. FETCH drives the program counter onto the address port and always moves to EXEC. EXEC decodes the returned word and does one of three things:

- It finishes the instruction and moves back to FETCH (EXEC→FETCH).
- For a load, it drives the data address and moves to LOAD (EXEC→LOAD).
- For a halt or an unknown opcode, it moves to HALT (EXEC→HALT).

LOAD writes the returned word to the destination register and moves to FETCH (LOAD→FETCH). HALT loops on itself (HALT→HALT) until a synchronous reset returns the core to FETCH.

Memory is a single port. The address, write data and write enable are driven in a cycle. Read data for that address is returned in the following cycle. The `halted` output reports the HALT state.

Top module: `tcpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to FETCH with the program counter at 0, all registers at 0 and both flags clear. After release, the first fetch address is 0 and `halted` is low. With no compare since reset, BEQ and BGT fall through.
- R2: Instruction word layout, with DW=32:
  - [31:27] opcode
  - [26] operand select
  - [25:22] Rd
  - [21:18] Rn
  - [17:0] field

  When bit 26 is 1, the second operand is the field zero-extended. When bit 26 is 0, the second operand is register Rm, where Rm = bits [3:0]. Opcodes: HLT 0, LDR 1, STR 2, ADD 3, SUB 4, MOV 5, CMP 6, B 7, BEQ 8, BNE 9, BGT 10, BLT 11, AND 12, ORR 13, EOR 14, MVN 15, LSL 16, LSR 17.
- R3: LDR writes Rd with the memory word at the address in field bits [AW-1:0]. STR writes Rd to that address.
- R4: ADD writes Rn+operand to Rd and SUB writes Rn−operand, both modulo 2^DW. MOV writes the operand to Rd.
- R5: AND, ORR and EOR write the bitwise AND, OR and XOR of Rn and the operand to Rd. MVN writes the inverse of the operand.
- R6: LSL and LSR shift Rn by the operand amount and fill with zeros. An amount of DW or more gives 0.
- R7: CMP sets the equal flag to (Rn == operand) and the greater flag to (Rn > operand), both unsigned. CMP writes no register and no memory. No other instruction changes the flags.
- R8: The branch target is field bits [AW-1:0].
  - B always jumps to the target.
  - BEQ jumps when the equal flag is set.
  - BNE jumps when the equal flag is clear.
  - BGT jumps when the greater flag is set.
  - BLT jumps when both flags are clear.

  A branch that is not taken goes on to the next word.
- R9: HLT, and every opcode from 18 to 31, raise `halted`. After that there is no further store and the address output stays frozen, until reset.
- R10: Every instruction except LDR takes two clock cycles and LDR takes three. A store holds `mem_we` high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | AW | Fetch, load or store address |
| mem_wdata | output | DW | Store data |
| mem_we | output | 1 | Store strobe |
| mem_rdata | input | DW | Word read at the address of the previous cycle |
| halted | output | 1 | High while the core is in HALT |

## Verification
The hardest case to reach from the ports is a conditional branch whose outcome depends on flags written by a CMP that is not the instruction just before it. Equal operands are also rare when stimulus is random. The branch programs therefore put an unrelated ADD between the compare and the branch. They force equal operands in about a third of the trials, and sometimes make the register value match the compare immediate. The taken or not-taken outcome and the untouched source registers are stored to memory, and the bench reads them there.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

    typedef enum logic [4:0] {
        OP_HLT = 5'd0,  OP_LDR = 5'd1,  OP_STR = 5'd2,  OP_ADD = 5'd3,
        OP_SUB = 5'd4,  OP_MOV = 5'd5,  OP_CMP = 5'd6,  OP_B   = 5'd7,
        OP_BEQ = 5'd8,  OP_BNE = 5'd9,  OP_BGT = 5'd10, OP_BLT = 5'd11,
        OP_AND = 5'd12, OP_ORR = 5'd13, OP_EOR = 5'd14, OP_MVN = 5'd15,
        OP_LSL = 5'd16, OP_LSR = 5'd17
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_EXEC,
        ST_LOAD,
        ST_HALT
    } state_e;

    typedef enum logic [3:0] {
        AL_ADD, AL_SUB, AL_PASS, AL_AND, AL_ORR,
        AL_EOR, AL_NOT, AL_SHL, AL_SHR
    } alu_op_e;

endpackage

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [IW-1:0] ra0,
    output logic [DW-1:0] rd0,
    input  logic [IW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic [IW-1:0] ra2,
    output logic [DW-1:0] rd2
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu import tcpu_pkg::*; #(
    parameter int DW = 32
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          eq,
    output logic          gt
);
    localparam int            SW   = $clog2(DW);
    localparam logic [DW-1:0] WLIM = DW;

    logic          too_far;
    logic [SW-1:0] shamt;

    assign too_far = (b >= WLIM);
    assign shamt   = b[SW-1:0];
    assign eq      = (a == b);
    assign gt      = (a > b);

    always_comb begin
        unique case (op)
            AL_ADD:  y = a + b;
            AL_SUB:  y = a - b;
            AL_PASS: y = b;
            AL_AND:  y = a & b;
            AL_ORR:  y = a | b;
            AL_EOR:  y = a ^ b;
            AL_NOT:  y = ~b;
            AL_SHL:  y = too_far ? '0 : (a << shamt);
            AL_SHR:  y = too_far ? '0 : (a >> shamt);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/tcpu_core.sv
module tcpu_core import tcpu_pkg::*; #(
    parameter int DW   = 32,
    parameter int AW   = 10,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);
    localparam int OPW     = 5;
    localparam int RFW     = 4;
    localparam int FW      = DW - OPW - 1 - 2 * RFW;
    localparam int IW      = $clog2(NREG);
    localparam int SEL_BIT = DW - OPW - 1;
    localparam int RD_LSB  = SEL_BIT - RFW;
    localparam int RN_LSB  = RD_LSB - RFW;

    state_e        state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [IW-1:0] ld_rd_q, ld_rd_d;
    logic          flag_eq, flag_gt;

    // instruction fields, valid while in EXEC
    logic [OPW-1:0] op_raw;
    logic           sel_imm;
    logic [IW-1:0]  rd_idx, rn_idx, rm_idx;
    logic [FW-1:0]  fld;
    logic [AW-1:0]  tgt;

    assign op_raw  = mem_rdata[DW-1 -: OPW];
    assign sel_imm = mem_rdata[SEL_BIT];
    assign rd_idx  = mem_rdata[RD_LSB +: IW];
    assign rn_idx  = mem_rdata[RN_LSB +: IW];
    assign rm_idx  = mem_rdata[IW-1:0];
    assign fld     = mem_rdata[FW-1:0];
    assign tgt     = fld[AW-1:0];

    logic [DW-1:0] rn_val, rm_val, rd_val, operand;
    logic          rf_we;
    logic [IW-1:0] rf_wa;
    logic [DW-1:0] rf_wd;
    alu_op_e       alu_op;
    logic [DW-1:0] alu_y;
    logic          alu_eq, alu_gt, cmp_fire;

    assign operand = sel_imm ? DW'(fld) : rm_val;

    tcpu_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
        .ra0(rn_idx), .rd0(rn_val),
        .ra1(rm_idx), .rd1(rm_val),
        .ra2(rd_idx), .rd2(rd_val)
    );

    tcpu_alu #(.DW(DW)) u_alu (
        .op(alu_op), .a(rn_val), .b(operand),
        .y(alu_y), .eq(alu_eq), .gt(alu_gt)
    );

    // state register, program counter and compare flags
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ld_rd_q <= '0;
            flag_eq <= 1'b0;
            flag_gt <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            ld_rd_q <= ld_rd_d;
            if (cmp_fire) begin
                flag_eq <= alu_eq;
                flag_gt <= alu_gt;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        ld_rd_d   = ld_rd_q;
        rf_we     = 1'b0;
        rf_wa     = rd_idx;
        rf_wd     = alu_y;
        alu_op    = AL_ADD;
        cmp_fire  = 1'b0;
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = rd_val;
        unique case (state_q)
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                state_d = ST_FETCH;
                pc_d    = pc_q + 1'b1;
                case (op_raw)
                    OP_LDR: begin
                        mem_addr = tgt;
                        ld_rd_d  = rd_idx;
                        state_d  = ST_LOAD;
                    end
                    OP_STR: begin
                        mem_addr = tgt;
                        mem_we   = 1'b1;
                    end
                    OP_ADD: begin rf_we = 1'b1; alu_op = AL_ADD;  end
                    OP_SUB: begin rf_we = 1'b1; alu_op = AL_SUB;  end
                    OP_MOV: begin rf_we = 1'b1; alu_op = AL_PASS; end
                    OP_AND: begin rf_we = 1'b1; alu_op = AL_AND;  end
                    OP_ORR: begin rf_we = 1'b1; alu_op = AL_ORR;  end
                    OP_EOR: begin rf_we = 1'b1; alu_op = AL_EOR;  end
                    OP_MVN: begin rf_we = 1'b1; alu_op = AL_NOT;  end
                    OP_LSL: begin rf_we = 1'b1; alu_op = AL_SHL;  end
                    OP_LSR: begin rf_we = 1'b1; alu_op = AL_SHR;  end
                    OP_CMP: cmp_fire = 1'b1;
                    OP_B:   pc_d = tgt;
                    OP_BEQ: if (flag_eq)              pc_d = tgt;
                    OP_BNE: if (!flag_eq)             pc_d = tgt;
                    OP_BGT: if (flag_gt)              pc_d = tgt;
                    OP_BLT: if (!flag_eq && !flag_gt) pc_d = tgt;
                    default: begin
                        state_d = ST_HALT;
                        pc_d    = pc_q;
                    end
                endcase
            end
            ST_LOAD: begin
                rf_we   = 1'b1;
                rf_wa   = ld_rd_q;
                rf_wd   = mem_rdata;
                state_d = ST_FETCH;
            end
            ST_HALT: state_d = ST_HALT;
        endcase
    end

    assign halted = (state_q == ST_HALT);
endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          halted,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          cmp_fire,
    input logic          flag_eq,
    input logic          flag_gt
);
    p_reset_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_addr == '0 && !halted));

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cmp_fire |=> $stable({flag_eq, flag_gt}));

    p_flags_excl_r7: assert property (@(posedge clk) disable iff (rst)
        flag_eq |-> !flag_gt);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    p_halt_no_write_r9: assert property (@(posedge clk) disable iff (rst)
        halted |-> !mem_we);

    p_halt_addr_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(mem_addr));

    p_store_single_r10: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);
endmodule

bind tcpu_core tcpu_core_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .halted(halted), .mem_we(mem_we),
    .mem_addr(mem_addr), .cmp_fire(cmp_fire),
    .flag_eq(flag_eq), .flag_gt(flag_gt)
);

// File: tb/sim_tcpu_core.sv
module sim_tcpu_core;
    localparam int DW = 32;
    localparam int AW = 10;
    localparam int O_HLT = 0,  O_LDR = 1,  O_STR = 2,  O_ADD = 3,  O_SUB = 4;
    localparam int O_MOV = 5,  O_CMP = 6,  O_B = 7,    O_BEQ = 8,  O_BNE = 9;
    localparam int O_BGT = 10, O_BLT = 11, O_AND = 12, O_ORR = 13, O_EOR = 14;
    localparam int O_MVN = 15, O_LSL = 16, O_LSR = 17;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          mem_we, halted;

    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [DW-1:0] mem [0:(1<<AW)-1];

    int nchk = 0, nfail = 0, we_cnt = 0, run_we = 0, plen = 0;
    logic [DW-1:0] prog [0:31];

    tcpu_core #(.DW(DW), .AW(AW), .NREG(16)) u0 (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (ld_we) mem[ld_addr] <= ld_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(negedge clk) if (mem_we) we_cnt <= we_cnt + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(int op, int im, int rd, int rn, int f);
        return {op[4:0], im[0], rd[3:0], rn[3:0], f[17:0]};
    endfunction

    function automatic logic [31:0] ref_alu(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            O_ADD:   return a + b;
            O_SUB:   return a - b;
            O_MOV:   return b;
            O_AND:   return a & b;
            O_ORR:   return a | b;
            O_EOR:   return a ^ b;
            O_MVN:   return ~b;
            O_LSL:   return (b >= 32) ? 32'h0 : (a << b[4:0]);
            O_LSR:   return (b >= 32) ? 32'h0 : (a >> b[4:0]);
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic ref_taken(int bop, logic [31:0] a, logic [31:0] b);
        case (bop)
            O_B:     return 1'b1;
            O_BEQ:   return a == b;
            O_BNE:   return a != b;
            O_BGT:   return a > b;
            default: return a < b;
        endcase
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    task automatic poke(input int a, input logic [31:0] d);
        ld_addr = a[AW-1:0];
        ld_data = d;
        ld_we   = 1'b1;
        @(negedge clk);
        ld_we   = 1'b0;
    endtask

    task automatic run(input int exp_cyc);
        int cyc, w0, bad;
        logic [AW-1:0] a0;
        for (int k = 0; k < plen; k++) poke(k, prog[k]);
        @(negedge clk);
        check("R1 halted low under reset", {31'b0, halted}, 32'h0);
        w0  = we_cnt;
        rst = 1'b0;
        check("R1 first fetch address", {22'b0, mem_addr}, 32'h0);
        cyc = 0;
        while (!halted && cyc < 600) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) check("R9 reached halt", 32'h0, 32'h1);
        if (exp_cyc >= 0) check("R10 cycles to halt", cyc, exp_cyc);
        run_we = we_cnt - w0;
        a0  = mem_addr;
        w0  = we_cnt;
        bad = 0;
        repeat (12) begin
            @(negedge clk);
            if (mem_addr != a0 || !halted) bad++;
        end
        check("R9 core frozen after halt", bad, 0);
        check("R9 no store after halt", we_cnt - w0, 0);
        rst  = 1'b1;
        plen = 0;
    endtask

    task automatic alu_case(input int op, input logic [31:0] a, input logic [31:0] b, input int imm);
        string tag;
        tag = (op == O_LSL || op == O_LSR) ? "R6" :
              (op == O_ADD || op == O_SUB || op == O_MOV) ? "R4" : "R5";
        emit(enc(O_LDR, 1, 1, 0, 100));
        emit(enc(O_LDR, 1, 2, 0, 101));
        emit(enc(op, 0, 3, 1, 2));
        emit(enc(op, 1, 4, 1, imm));
        emit(enc(O_STR, 1, 3, 0, 200));
        emit(enc(O_STR, 1, 4, 0, 201));
        emit(enc(O_HLT, 0, 0, 0, 0));
        poke(100, a); poke(101, b); poke(200, SENT); poke(201, SENT);
        run(16);
        check({tag, " register operand"}, mem[200], ref_alu(op, a, b));
        check({tag, " R2 immediate operand"}, mem[201], ref_alu(op, a, {14'b0, imm[17:0]}));
    endtask

    task automatic br_case(input int bop, input logic [31:0] a, input logic [31:0] b,
                           input int use_imm, input int imm);
        logic [31:0] bv;
        logic        tk;
        bv = use_imm != 0 ? {14'b0, imm[17:0]} : b;
        tk = ref_taken(bop, a, bv);
        emit(enc(O_LDR, 1, 1, 0, 100));
        emit(enc(O_LDR, 1, 2, 0, 101));
        emit(enc(O_MOV, 1, 5, 0, 0));
        emit(use_imm != 0 ? enc(O_CMP, 1, 0, 1, imm) : enc(O_CMP, 0, 0, 1, 2));
        emit(enc(O_ADD, 1, 6, 1, 1));
        emit(enc(bop, 1, 0, 0, 7));
        emit(enc(O_MOV, 1, 5, 0, 1));
        emit(enc(O_STR, 1, 5, 0, 200));
        emit(enc(O_STR, 1, 1, 0, 201));
        emit(enc(O_STR, 1, 2, 0, 202));
        emit(enc(O_HLT, 0, 0, 0, 0));
        poke(100, a); poke(101, b);
        poke(200, SENT); poke(201, SENT); poke(202, SENT);
        run(tk ? 22 : 24);
        check("R8 branch outcome after R7 compare", mem[200], tk ? 32'h0 : 32'h1);
        check("R7 compare leaves Rn intact", mem[201], a);
        check("R7 compare leaves Rm intact", mem[202], b);
    endtask

    initial begin
        int alu_ops[9];
        int br_ops[5];
        logic [31:0] a, b;
        int imm, op;
        alu_ops = '{O_ADD, O_SUB, O_MOV, O_AND, O_ORR, O_EOR, O_MVN, O_LSL, O_LSR};
        br_ops  = '{O_B, O_BEQ, O_BNE, O_BGT, O_BLT};
        void'($urandom(32'd2024));

        // R1: registers and flags clear after reset
        emit(enc(O_STR, 1, 7, 0, 200));
        emit(enc(O_BEQ, 1, 0, 0, 4));
        emit(enc(O_BGT, 1, 0, 0, 4));
        emit(enc(O_MOV, 1, 2, 0, 5));
        emit(enc(O_STR, 1, 2, 0, 201));
        emit(enc(O_HLT, 0, 0, 0, 0));
        poke(200, SENT); poke(201, SENT);
        run(12);
        check("R1 register reads zero", mem[200], 32'h0);
        check("R1 clear flags fall through", mem[201], 32'h5);

        // R3 / R10: load and store timing
        emit(enc(O_LDR, 1, 1, 0, 100));
        emit(enc(O_STR, 1, 1, 0, 202));
        emit(enc(O_HLT, 0, 0, 0, 0));
        poke(100, 32'h1357_9BDF); poke(202, SENT);
        run(7);
        check("R3 load then store", mem[202], 32'h1357_9BDF);
        check("R10 single store strobe", run_we, 1);

        // directed arithmetic corners
        alu_case(O_ADD, 32'hFFFF_FFFF, 32'h1, 1);
        alu_case(O_SUB, 32'h0, 32'h1, 3);
        alu_case(O_LSL, 32'h1, 32'd32, 31);
        alu_case(O_LSR, 32'h8000_0000, 32'd31, 40);
        alu_case(O_LSL, 32'hFFFF_FFFF, 32'd33, 0);
        alu_case(O_MVN, 32'h0F0F_0000, 32'h0, 18'h3FFFF);

        for (int i = 0; i < 200; i++) begin
            op  = alu_ops[$urandom % 9];
            a   = $urandom;
            b   = $urandom;
            imm = int'($urandom % 32'h40000);
            if (op == O_LSL || op == O_LSR) begin
                b   = $urandom % 40;
                imm = int'($urandom % 40);
            end
            alu_case(op, a, b, imm);
        end

        // directed compares: equal, less, greater for each branch
        for (int k = 0; k < 5; k++) begin
            br_case(br_ops[k], 32'h55, 32'h55, 0, 0);
            br_case(br_ops[k], 32'h10, 32'hFFFF_0000, 0, 0);
            br_case(br_ops[k], 32'h8000_0000, 32'h7FFF_FFFF, 0, 0);
        end

        for (int i = 0; i < 150; i++) begin
            int ui;
            op  = br_ops[$urandom % 5];
            ui  = int'($urandom % 2);
            imm = int'($urandom % 32'h40000);
            a   = $urandom;
            b   = $urandom;
            if ($urandom % 3 == 0) b = a;
            if (ui != 0) begin
                if ($urandom % 3 == 0) a = {14'b0, imm[17:0]};
                else if ($urandom % 2 == 0) a = $urandom % 32'h40000;
            end
            br_case(op, a, b, ui, imm);
        end

        // R9: undefined opcodes halt and suppress later stores
        for (int k = 0; k < 3; k++) begin
            int uo;
            uo = (k == 0) ? 18 : (k == 1) ? 25 : 31;
            emit(enc(O_MOV, 1, 1, 0, 7));
            emit(enc(uo, 1, 0, 0, 0));
            emit(enc(O_STR, 1, 1, 0, 200));
            emit(enc(O_HLT, 0, 0, 0, 0));
            poke(200, SENT);
            run(4);
            check("R9 undefined opcode halts", mem[200], SENT);
        end
        emit(enc(O_HLT, 0, 0, 0, 0));
        emit(enc(O_STR, 1, 0, 0, 200));
        poke(200, SENT);
        run(2);
        check("R9 halt blocks following store", mem[200], SENT);
        @(negedge clk);
        check("R9 reset clears halted", {31'b0, halted}, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nfail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule